// File: doc/BRIEF.md
# I2C SCL and SDA Timing Generator

This block produces the serial clock of an I2C master and the timing points a bit engine needs around it. SCL is driven open-drain: the block only ever pulls the line low or lets it go. The low phase and the high phase each last a programmable number of system clocks. There are two pairs of counts, one for standard speed and one for fast speed. A control input enables the generator and chooses which pair is in use.

The high phase is not timed from the moment SCL is released. Its counter starts only when SCL is actually sampled high. A slave that holds the line low therefore lengthens the low time on the wire, which is clock stretching. During the low phase a programmable hold count sets when SDA may change after the falling edge. A programmable setup count guarantees a minimum distance between that change and the next release of SCL.

Four one-cycle strobes drive the bit engine: SCL seen rising, SCL about to fall, SDA change point and SDA sample point. All counts are loaded through a small write port, and only while the generator is disabled.

Top module: `i2c_scl_timer`

## Requirements
- R1: While the enable bit (ctrl bit 0) is 0, `scl_pull_low` is 0 from the next cycle onwards. `scl_rise`, `scl_fall` and `sda_sample` are then 0. After reset the block is disabled.
- R2: While enabled, every low phase keeps `scl_pull_low` at 1 for exactly the effective low count of system clocks.
- R3: The high phase lasts the effective high count of cycles in which `scl_in` is 1. `scl_rise` pulses in the first of those cycles. `scl_fall` pulses in the last of them, and `scl_pull_low` is 1 from the next cycle.
- R4: When ctrl bit 2 is 1, the fast-speed pair is used, even if bit 1 is also set. Otherwise the standard-speed pair (bit 1) is used.
- R5: Programmed high and low counts below 6 act as 6. Counts above 65525 act as 65525.
- R6: After reset the counts are 0x264 high and 0x2C2 low for standard speed, 0x6E high and 0xCF low for fast speed, 1 for hold and 0x64 for setup.
- R7: `sda_change` pulses once per low phase, at cycle index `hold` of that phase. Index 0 is the first cycle with `scl_pull_low` at 1.
- R8: The setup count acts as 2 when it is programmed below 2. The `sda_change` index never exceeds low count minus effective setup, and is 0 if that difference is not positive. The setup limit wins over hold.
- R9: `sda_sample` pulses at index high/2 (rounded down) of the cycles in which SCL has been seen high during a high phase.
- R10: While the generator leaves SCL released but `scl_in` stays 0, the high phase does not advance. A stretch of S cycles makes the released time S plus the high count, and moves `scl_rise` to index S.
- R11: The write port (`cfg_we`, `cfg_addr`, `cfg_wdata`) uses this address map: 0 standard high, 1 standard low, 2 fast high, 3 fast low, 4 hold (data bits 7:0), 5 setup (data bits 7:0). A write takes effect only while the block is disabled; a write while enabled changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 3 | Bit 0 enable, bit 1 standard speed, bit 2 fast speed |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | 3 | Count register select |
| cfg_wdata | input | 16 | Count register write data |
| scl_in | input | 1 | Synchronised SCL line level |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | First cycle SCL is seen high in a high phase |
| scl_fall | output | 1 | Last high cycle before SCL is pulled low |
| sda_change | output | 1 | Point at which SDA may be changed |
| sda_sample | output | 1 | Point at which SDA is sampled |

## Verification
The assertions assume that `scl_in` is already synchronised to `clk` and never reads 1 while the block itself pulls SCL low. This is the wired-AND behaviour of an open-drain line. The bench keeps to this by building `scl_in` as the AND of the released line and its own stretching pull.

The bench changes `ctrl` and writes counts only at falling clock edges. Counts are written only while the block is disabled, except in the one test that checks a write made while enabled is ignored.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int CW        = 16,
  parameter int HW        = 8,
  parameter int MIN_CNT   = 6,
  parameter int MAX_CNT   = 65525,
  parameter int MIN_SETUP = 2,
  parameter int SS_HI_RST = 'h264,
  parameter int SS_LO_RST = 'h2C2,
  parameter int FS_HI_RST = 'h6E,
  parameter int FS_LO_RST = 'hCF,
  parameter int HOLD_RST  = 1,
  parameter int SETUP_RST = 'h64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ctrl,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          scl_in,
  output logic          scl_pull_low,
  output logic          scl_rise,
  output logic          scl_fall,
  output logic          sda_change,
  output logic          sda_sample
);
  localparam int PAD = CW - HW;

  logic [CW-1:0] ss_hi, ss_lo, fs_hi, fs_lo, cnt;
  logic [HW-1:0] hold_q, setup_q;
  logic          phase_low;

  function automatic logic [CW-1:0] clamp_cnt(input logic [CW-1:0] v);
    if (v < CW'(MIN_CNT)) return CW'(MIN_CNT);
    if (v > CW'(MAX_CNT)) return CW'(MAX_CNT);
    return v;
  endfunction

  wire en   = ctrl[0];
  wire fast = ctrl[2];

  wire [CW-1:0] hi_eff    = clamp_cnt(fast ? fs_hi : ss_hi);
  wire [CW-1:0] lo_eff    = clamp_cnt(fast ? fs_lo : ss_lo);
  wire [CW-1:0] hold_w    = {{PAD{1'b0}}, hold_q};
  wire [CW-1:0] setup_w   = (setup_q < HW'(MIN_SETUP)) ? CW'(MIN_SETUP) : {{PAD{1'b0}}, setup_q};
  wire [CW-1:0] chg_limit = (lo_eff > setup_w) ? lo_eff - setup_w : '0;
  wire [CW-1:0] chg_pt    = (hold_w < chg_limit) ? hold_w : chg_limit;

  wire hi_last = cnt == hi_eff - CW'(1);
  wire lo_last = cnt == lo_eff - CW'(1);
  wire hi_seen = en & ~phase_low & scl_in;

  assign scl_pull_low = phase_low;
  assign scl_rise     = hi_seen & (cnt == '0);
  assign scl_fall     = hi_seen & hi_last;
  assign sda_sample   = hi_seen & (cnt == (hi_eff >> 1));
  assign sda_change   = en & phase_low & (cnt == chg_pt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_hi     <= CW'(SS_HI_RST);
      ss_lo     <= CW'(SS_LO_RST);
      fs_hi     <= CW'(FS_HI_RST);
      fs_lo     <= CW'(FS_LO_RST);
      hold_q    <= HW'(HOLD_RST);
      setup_q   <= HW'(SETUP_RST);
      phase_low <= 1'b0;
      cnt       <= '0;
    end else if (!en) begin
      phase_low <= 1'b0;
      cnt       <= '0;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: ss_hi   <= cfg_wdata;
          3'd1: ss_lo   <= cfg_wdata;
          3'd2: fs_hi   <= cfg_wdata;
          3'd3: fs_lo   <= cfg_wdata;
          3'd4: hold_q  <= cfg_wdata[HW-1:0];
          3'd5: setup_q <= cfg_wdata[HW-1:0];
          default: ;
        endcase
      end
    end else if (phase_low) begin
      if (lo_last) begin
        phase_low <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (scl_in) begin
      if (hi_last) begin
        phase_low <= 1'b1;
        cnt       <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ctrl,
  input logic       scl_in,
  input logic       scl_pull_low,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       sda_change,
  input logic       sda_sample
);
  a_r1_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> !scl_pull_low);

  a_r3_fall_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> scl_pull_low);

  a_r3_rise_on_high_line: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl_in && !scl_pull_low));

  a_r7_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change |-> scl_pull_low);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, sda_change, sda_sample}));

  a_r10_stretch_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_low && !scl_in) |=> !scl_pull_low);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .scl_in(scl_in),
  .scl_pull_low(scl_pull_low), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .sda_change(sda_change), .sda_sample(sda_sample)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ctrl = 3'b000;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        stretch_low = 1'b0;
  logic        scl_in, scl_pull_low, scl_rise, scl_fall, sda_change, sda_sample;

  int n_chk = 0, n_bad = 0;
  int lo_len, chg_idx, hi_len, smp_idx, rise_idx, fall_idx;

  always #5 clk = ~clk;
  assign scl_in = ~scl_pull_low & ~stretch_low;

  i2c_scl_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .scl_in(scl_in), .scl_pull_low(scl_pull_low),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_change(sda_change),
    .sda_sample(sda_sample)
  );

  localparam int NV = 6;
  localparam int V_FAST[NV]  = '{0, 1, 1, 0, 0, 1};
  localparam int V_HI[NV]    = '{20, 8, 2, 10, 7, 9};
  localparam int V_LO[NV]    = '{30, 12, 3, 10, 40, 9};
  localparam int V_HOLD[NV]  = '{3, 1, 0, 9, 2, 5};
  localparam int V_SETUP[NV] = '{5, 2, 0, 4, 1, 200};
  localparam int E_HI[NV]    = '{20, 8, 6, 10, 7, 9};
  localparam int E_LO[NV]    = '{30, 12, 6, 10, 40, 9};
  localparam int E_CHG[NV]   = '{3, 1, 0, 6, 2, 0};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input int stretch);
    @(negedge clk);
    while (scl_pull_low) @(negedge clk);
    while (!scl_pull_low) @(negedge clk);
    stretch_low = (stretch > 0);
    #1;
    lo_len = 0; chg_idx = -1;
    while (scl_pull_low) begin
      if (sda_change && chg_idx < 0) chg_idx = lo_len;
      lo_len++;
      @(negedge clk);
      stretch_low = (stretch > 0);
      #1;
    end
    hi_len = 0; smp_idx = -1; rise_idx = -1; fall_idx = -1;
    while (!scl_pull_low) begin
      stretch_low = (hi_len < stretch);
      #1;
      if (scl_rise && rise_idx < 0) rise_idx = hi_len;
      if (sda_sample && smp_idx < 0) smp_idx = hi_len;
      if (scl_fall && fall_idx < 0) fall_idx = hi_len;
      hi_len++;
      @(negedge clk);
    end
    stretch_low = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset pull", int'(scl_pull_low), 0);
    check("R1 reset strobes", int'({scl_rise, scl_fall, sda_sample}), 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      seen |= int'({scl_pull_low, scl_rise, scl_fall, sda_sample});
    end
    check("R1 disabled idle", seen, 0);

    // R6 standard defaults
    @(negedge clk); ctrl = 3'b011;
    measure(0);
    check("R6 std low default", lo_len, 'h2C2);
    check("R6 std high default", hi_len, 'h264);
    check("R7 default hold", chg_idx, 1);
    check("R9 default sample", smp_idx, 'h264 / 2);
    check("R3 rise index", rise_idx, 0);
    check("R3 fall index", fall_idx, 'h264 - 1);

    // R11 write while enabled is ignored
    wr(1, 50);
    measure(0);
    check("R11 ignored write", lo_len, 'h2C2);

    // R4 both speed bits set selects fast pair
    @(negedge clk); ctrl = 3'b000;
    @(negedge clk); ctrl = 3'b111;
    measure(0);
    check("R4 fast low", lo_len, 'hCF);
    check("R4 fast high", hi_len, 'h6E);
    @(negedge clk); ctrl = 3'b000;
    @(negedge clk); #1;
    check("R1 after disable", int'(scl_pull_low), 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk); ctrl = 3'b000;
      wr(V_FAST[v] ? 2 : 0, V_HI[v]);
      wr(V_FAST[v] ? 3 : 1, V_LO[v]);
      wr(4, V_HOLD[v]);
      wr(5, V_SETUP[v]);
      @(negedge clk); ctrl = V_FAST[v] ? 3'b101 : 3'b011;
      measure(0);
      check($sformatf("R2 R5 low vec%0d", v), lo_len, E_LO[v]);
      check($sformatf("R3 R5 high vec%0d", v), hi_len, E_HI[v]);
      check($sformatf("R7 R8 change vec%0d", v), chg_idx, E_CHG[v]);
      check($sformatf("R9 sample vec%0d", v), smp_idx, E_HI[v] / 2);
      check($sformatf("R3 fall vec%0d", v), fall_idx, E_HI[v] - 1);
    end

    // R10 stretching on standard pair (high 7, low 40)
    @(negedge clk); ctrl = 3'b000;
    @(negedge clk); ctrl = 3'b011;
    measure(5);
    check("R10 stretched high", hi_len, 5 + 7);
    check("R10 rise moved", rise_idx, 5);
    check("R10 sample moved", smp_idx, 5 + 3);
    check("R10 fall moved", fall_idx, 5 + 6);
    check("R10 low unchanged", lo_len, 40);

    // R5 upper clamp
    @(negedge clk); ctrl = 3'b000;
    wr(1, 16'hFFFF);
    @(negedge clk); ctrl = 3'b011;
    measure(0);
    check("R5 upper clamp", lo_len, 65525);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule